// File: doc/BRIEF.md
# Port Pin Direction Override Controller

This block drives an eight-pin general-purpose port. Software sets each pin's direction and output level through two bus registers. Several on-chip functions can take a pin over: a display segment driver, an I2C unit, an SPI unit and a clock-output function. Each pin has its own fixed priority order, and only the takeovers that apply to that pin appear in its order. The block resolves that order and drives an output-enable and an input-buffer-enable for every pin.

Pin levels come back into the chip through a two-flop synchronizer on the bus clock. A read of the data register returns, for each bit, one of three values. A pin driven as an output returns its latched output value. A pin taken by the segment driver returns zero. A pin used as an input returns its level as seen through the synchronizer. The peripherals themselves are not part of the block. Only their enable, routing and direction signals enter it.

Top module: `port_dir_ctrl`

## Requirements
- R1: A synchronous reset with rst_n low clears the direction register to all inputs (0) and the data register to 0. It also clears both synchronizer stages.
- R2: A write with bus_we high and bus_sel=1 loads the direction register, where bit value 1 means output. A write with bus_sel=0 loads the data register. The new value is in place after the clock edge. pin_out always shows the data register.
- R3: When lcd_en[i] is high, pin i has pin_oe[i]=0 and pin_ie[i]=0, whatever the other controls are. When lcd_en[i] is low, pin_ie[i]=1.
- R4: When the segment enable is off, pins 7 to 4 take their direction from the direction register bit. No other control affects them.
- R5: On pins 3 and 0, with the segment enable off, iic_route and iic_en both high make the pin direction follow the I2C unit. Pin 3 uses iic_dir[1] and pin 0 uses iic_dir[0].
- R6: On pins 3 to 0, with no higher-priority override active, spi_route and spi_en both high make pin i follow spi_dir[i].
- R7: On pin 2, when neither the segment enable nor the SPI unit holds the pin, clkout_en high forces the pin to output. The clock output has no effect on any other pin.
- R8: On pin 1, the direction comes from SPI when SPI holds the pin, and from the direction register otherwise. The I2C unit and the clock output have no effect on pin 1.
- R9: When bus_sel=0 and pin i is a non-segment input, bus_rdata[i] equals the pin_in[i] value sampled two clock edges earlier.
- R10: When bus_sel=0, bus_rdata[i] is the data register bit if pin i resolves to output, and 0 if lcd_en[i] is high. When bus_sel=1, bus_rdata returns the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 data, 1 direction |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| lcd_en | input | 8 | Per-pin segment driver enable |
| iic_route | input | 1 | I2C routed to this port |
| iic_en | input | 1 | I2C unit enabled |
| iic_dir | input | 2 | I2C direction for pins 3 (bit 1) and 0 (bit 0) |
| spi_route | input | 1 | SPI routed to this port |
| spi_en | input | 1 | SPI unit enabled |
| spi_dir | input | 4 | SPI direction for pins 3 to 0 |
| clkout_en | input | 1 | Clock-output function enable (pin 2) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output levels |
| pin_oe | output | 8 | Pad output enables |
| pin_ie | output | 8 | Pad input-buffer enables |

## Verification
Two things can happen in the same cycle: a bus write to the direction register, and an active peripheral override on the same pin. The write must land in the register while the pin keeps following the override. The readback must then also switch between the latched value and the synchronized level. The bench provokes this by drawing writes, routing bits, enables and per-pin segment enables at random every cycle. It judges each cycle against a reference model built from the priority rules and a two-edge history of the pin inputs, and it reads the direction register back to confirm that each write landed.

// File: rtl/port_dir_ctrl.sv
module port_dir_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_we,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] lcd_en,
  input  logic         iic_route,
  input  logic         iic_en,
  input  logic [1:0]   iic_dir,
  input  logic         spi_route,
  input  logic         spi_en,
  input  logic [3:0]   spi_dir,
  input  logic         clkout_en,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_ie
);

  logic [W-1:0] dir_q, data_q, sync1_q, sync2_q;
  logic [W-1:0] eff_dir;
  logic         iic_on, spi_on;

  assign iic_on = iic_route & iic_en;
  assign spi_on = spi_route & spi_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '0;
      data_q  <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (bus_we && bus_sel)  dir_q  <= bus_wdata;
      if (bus_we && !bus_sel) data_q <= bus_wdata;
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    eff_dir = dir_q;
    eff_dir[0] = iic_on ? iic_dir[0] : (spi_on ? spi_dir[0] : dir_q[0]);
    eff_dir[1] = spi_on ? spi_dir[1] : dir_q[1];
    eff_dir[2] = spi_on ? spi_dir[2] : (clkout_en ? 1'b1 : dir_q[2]);
    eff_dir[3] = iic_on ? iic_dir[1] : (spi_on ? spi_dir[3] : dir_q[3]);
  end

  assign pin_out   = data_q;
  assign pin_oe    = eff_dir & ~lcd_en;
  assign pin_ie    = ~lcd_en;
  assign bus_rdata = bus_sel ? dir_q
                   : ~lcd_en & ((eff_dir & data_q) | (~eff_dir & sync2_q));

  logic [1:0] live_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (dir_q == '0 && data_q == '0 && sync2_q == '0));

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel) |=> (dir_q == $past(bus_wdata)));

  a_r7_clkout_force: assert property (@(posedge clk) disable iff (!rst_n)
    (clkout_en && !lcd_en[2] && !spi_on) |-> pin_oe[2]);

  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt >= 2'd2 && !bus_sel && !lcd_en[7] && !dir_q[7])
      |-> (bus_rdata[7] == $past(pin_in[7], 2)));

  for (genvar i = 0; i < W; i++) begin : g_lcd
    a_r3_lcd_off: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_en[i] |-> (!pin_oe[i] && !pin_ie[i] && (bus_sel || !bus_rdata[i])));
  end

endmodule

// File: tb/test_port_dir_ctrl.sv
module test_port_dir_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [7:0] lcd_en = '0;
  logic       iic_route = 1'b0, iic_en = 1'b0;
  logic [1:0] iic_dir = '0;
  logic       spi_route = 1'b0, spi_en = 1'b0;
  logic [3:0] spi_dir = '0;
  logic       clkout_en = 1'b0;
  logic [7:0] pin_in = '0, pin_out, pin_oe, pin_ie;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_dir = '0, m_data = '0, m_s1 = '0, m_s2 = '0;

  always #10 clk = ~clk;

  port_dir_ctrl i_port_dir_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lcd_en(lcd_en),
    .iic_route(iic_route), .iic_en(iic_en), .iic_dir(iic_dir),
    .spi_route(spi_route), .spi_en(spi_en), .spi_dir(spi_dir),
    .clkout_en(clkout_en), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_ie(pin_ie)
  );

  function automatic logic [7:0] want_dir();
    logic [7:0] d = m_dir;
    logic i2c = iic_route & iic_en;
    logic spi = spi_route & spi_en;
    if (i2c) d[0] = iic_dir[0]; else if (spi) d[0] = spi_dir[0];
    if (spi) d[1] = spi_dir[1];
    if (spi) d[2] = spi_dir[2]; else if (clkout_en) d[2] = 1'b1;
    if (i2c) d[3] = iic_dir[1]; else if (spi) d[3] = spi_dir[3];
    return d;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [7:0] d = want_dir();
    check("R2 pin_out", pin_out, m_data);
    check("R3 pin_ie", pin_ie, ~lcd_en);
    check("R4 upper oe", pin_oe & 8'hF0, d & ~lcd_en & 8'hF0);
    check("R5/R6/R7/R8 lower oe", pin_oe & 8'h0F, d & ~lcd_en & 8'h0F);
    if (bus_sel) check("R10 dir read", bus_rdata, m_dir);
    else begin
      check("R9 input read", bus_rdata & ~d & ~lcd_en, m_s2 & ~d & ~lcd_en);
      check("R10 output read", bus_rdata & (d | lcd_en), m_data & d & ~lcd_en);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst_n) begin
      m_dir = '0; m_data = '0; m_s1 = '0; m_s2 = '0;
    end else begin
      if (bus_we && bus_sel) m_dir = bus_wdata;
      if (bus_we && !bus_sel) m_data = bus_wdata;
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
    @(negedge clk);
  endtask

  task automatic randomize_inputs(int ovr);
    bus_sel   = 1'($urandom);
    bus_we    = ($urandom % 3) == 0;
    bus_wdata = 8'($urandom);
    lcd_en    = (ovr != 0) ? (8'($urandom) & 8'($urandom)) : 8'h00;
    iic_route = (ovr != 0) && 1'($urandom);
    iic_en    = 1'($urandom);
    iic_dir   = 2'($urandom);
    spi_route = (ovr != 0) && 1'($urandom);
    spi_en    = 1'($urandom);
    spi_dir   = 4'($urandom);
    clkout_en = (ovr != 0) && 1'($urandom);
    pin_in    = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) step();
    #2;
    check("R1 reset oe", pin_oe, 8'h00);
    check("R1 reset out", pin_out, 8'h00);
    rst_n = 1'b1;
    bus_sel = 1'b1;
    #2 check("R1 reset dir", bus_rdata, 8'h00);

    // Directed: inputs only, pin 7 toggles, readback lags two edges (R9)
    bus_we = 1'b0; bus_sel = 1'b0;
    pin_in = 8'h80; step(); #2 check("R9 one edge", bus_rdata & 8'h80, 8'h00);
    step(); #2 check("R9 two edges", bus_rdata & 8'h80, 8'h80);

    // Directed: clock output with SPI active leaves pin 2 to SPI (R7, R6)
    spi_route = 1'b1; spi_en = 1'b1; spi_dir = 4'h0; clkout_en = 1'b1;
    #2 check("R6 spi over clkout", pin_oe & 8'h04, 8'h00);
    spi_en = 1'b0;
    #2 check("R7 clkout forces", pin_oe & 8'h04, 8'h04);
    check("R7 no effect on others", pin_oe & 8'hFB, 8'h00);

    // Directed: I2C beats SPI on pins 3 and 0, not pin 1 (R5, R8)
    iic_route = 1'b1; iic_en = 1'b1; iic_dir = 2'b10; spi_en = 1'b1; spi_dir = 4'hF;
    #2 check("R5 i2c priority", pin_oe & 8'h0B, 8'h0A);

    // Directed: segment enable beats everything, while a direction write lands (R3)
    lcd_en = 8'hFF; bus_we = 1'b1; bus_sel = 1'b1; bus_wdata = 8'hFF;
    #2 check("R3 lcd off", pin_oe | pin_ie, 8'h00);
    step();
    bus_we = 1'b0;
    #2 check("R2 dir landed", bus_rdata, 8'hFF);
    check("R3 lcd still off", pin_oe, 8'h00);

    for (int n = 0; n < 3000; n++) begin
      randomize_inputs(n % 4);
      if (n == 1500) rst_n = 1'b0;
      else if (n == 1502) rst_n = 1'b1;
      #2 check_all();
      step();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule